// File: doc/BRIEF.md
# Line timing and sandcastle generator

This block takes a clock that is locked to the video line at 13.5 MHz. It divides that clock down to the line rate through a cascade of three counter stages: 16, then 2, then 27. The result is 864 clocks per line.

From the combined line count it decodes three line-rate pulses:
- a horizontal drive pulse whose start can be moved to one of four positions around the line reference;
- a burst-key pulse whose width follows a 50/60 Hz mode select;
- a horizontal blanking pulse.

The block merges these pulses with a vertical blanking input into a single 2-bit sandcastle level code. A later analog stage turns that code into voltage levels.

The horizontal offset select and the 50/60 select are taken on the last clock of each line. A change made part way through a line therefore never cuts or stretches a pulse already under way. All outputs come from registers, so they share one clock of latency after the count that decodes them. Timing below is measured in clocks after the cycle in which `lineStrobe` is high, counted as clock 0.

Top module: `line_sandcastle`

## Requirements
- R1: `lineStrobe` is high for exactly one clock, and successive strobes are 864 clocks apart.
- R2: On the first clock edge with reset released, `lineStrobe` rises.
- R3: While reset is asserted, `lineStrobe` and `hPulse` read 0 and `sandcastle` reads 0, even when `vBlank` is high. This holds from the first clock edge after reset is applied.
- R4: `hPulse` rises at the clock after the strobe given by `hOffSel`: 0 gives 846 (18 clocks early), 1 gives 853 (11 early), 2 gives 54, and 3 gives 70.
- R5: Every `hPulse` stays high for exactly 49 clocks, including a pulse that runs across the line boundary.
- R6: `hOffSel` and `sel60` are sampled only on the last clock of a line. A change during a line leaves that line's pulse positions and widths unchanged and applies from the next line.
- R7: The burst key starts at clock 34 and lasts 58 clocks when `sel60`=0 or 51 clocks when `sel60`=1. While it is active, `sandcastle` reads 3.
- R8: Horizontal blanking covers clocks 54 to 212 (159 clocks). Where it is active and the burst key is not, `sandcastle` reads 2. The burst key takes priority over blanking.
- R9: When `vBlank` is high and neither line pulse is active, `sandcastle` reads 1 one clock later. When `vBlank` is low and no pulse is active, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hOffSel | input | 2 | Horizontal pulse start position select |
| sel60 | input | 1 | 1 selects the 60 Hz burst-key width, 0 the 50 Hz width |
| vBlank | input | 1 | Vertical blanking request |
| lineStrobe | output | 1 | One-clock pulse once per line |
| hPulse | output | 1 | Horizontal drive pulse |
| sandcastle | output | 2 | Level code: 0 low, 1 vertical blank, 2 horizontal blank, 3 burst key |

## Verification
The bench builds the block with its default parameters: stages of 16, 2 and 27, a 49-clock drive pulse, and the stated burst and blanking positions. Each line is therefore long enough that all four start offsets can be seen, including the two that place the pulse across the line boundary. Each window the bench samples spans a full line plus 60 clocks, so a wrapped pulse can be measured end to end. Both burst-key widths and the vertical level appear, both alone and under the line pulses. The bench also changes the selects in mid-line and then looks at the following line.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Decoded events handed from the control to the datapath each clock.
  typedef struct packed {
    logic lineTick;
    logic hStart;
    logic bkOn;
    logic bkOff;
    logic hbOn;
    logic hbOff;
  } lscStrobe_t;

endpackage

// File: rtl/lsc_control.sv
module lsc_control
  import lsc_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 864,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned H_START0  = 846,
  parameter int unsigned H_START1  = 853,
  parameter int unsigned H_START2  = 54,
  parameter int unsigned H_START3  = 70,
  parameter int unsigned BK_START  = 34,
  parameter int unsigned BK_W50    = 58,
  parameter int unsigned BK_W60    = 51,
  parameter int unsigned HB_START  = 54,
  parameter int unsigned HB_W      = 159
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] lineCount,
  input  logic [1:0]       hOffSel,
  input  logic             sel60,
  output lscStrobe_t       strb
);

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(LINE_CLKS - 1);
  localparam logic [CNT_W-1:0] BK_ON     = CNT_W'(BK_START);
  localparam logic [CNT_W-1:0] BK_END50  = CNT_W'(BK_START + BK_W50);
  localparam logic [CNT_W-1:0] BK_END60  = CNT_W'(BK_START + BK_W60);
  localparam logic [CNT_W-1:0] HB_ON     = CNT_W'(HB_START);
  localparam logic [CNT_W-1:0] HB_END    = CNT_W'(HB_START + HB_W);
  localparam int unsigned      H_STARTS[4] = '{H_START0, H_START1, H_START2, H_START3};

  logic [1:0]       offQ;
  logic             sel60Q;
  logic [CNT_W-1:0] hStartCnt;

  // Mode inputs are taken once per line so no pulse is cut mid-flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      offQ   <= 2'd0;
      sel60Q <= 1'b0;
    end else if (lineCount == LAST_CNT) begin
      offQ   <= hOffSel;
      sel60Q <= sel60;
    end
  end

  assign hStartCnt = CNT_W'(H_STARTS[offQ]);

  always_comb begin
    strb          = '0;
    strb.lineTick = (lineCount == '0);
    strb.hStart   = (lineCount == hStartCnt);
    strb.bkOn     = (lineCount == BK_ON);
    strb.bkOff    = (lineCount == (sel60Q ? BK_END60 : BK_END50));
    strb.hbOn     = (lineCount == HB_ON);
    strb.hbOff    = (lineCount == HB_END);
  end

endmodule

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 16,
  parameter int unsigned MID_DIV  = 2,
  parameter int unsigned LINE_DIV = 27,
  parameter int unsigned H_WIDTH  = 49,
  parameter int unsigned CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  lscStrobe_t       strb,
  input  logic             vBlank,
  output logic [CNT_W-1:0] lineCount,
  output logic             lineStrobe,
  output logic             hPulse,
  output logic [1:0]       sandcastle
);

  localparam int unsigned NSTAGE = 3;
  localparam int unsigned STAGE_DIV[NSTAGE] = '{PRE_DIV, MID_DIV, LINE_DIV};
  localparam int unsigned STAGE_WGT[NSTAGE] = '{1, PRE_DIV, PRE_DIV * MID_DIV};
  localparam int unsigned HW_W = $clog2(H_WIDTH + 1);

  logic [NSTAGE-1:0] carry;
  logic [CNT_W-1:0]  part [NSTAGE];

  assign carry[0] = 1'b1;

  // Divider cascade: each stage advances when all lower stages wrap.
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [CNT_W-1:0] stVal;
    logic             atTop;

    assign atTop = (stVal == CNT_W'(STAGE_DIV[g] - 1));

    always_ff @(posedge clk) begin
      if (rst)
        stVal <= '0;
      else if (carry[g])
        stVal <= atTop ? '0 : stVal + 1'b1;
    end

    if (g < NSTAGE - 1) begin : g_carry
      assign carry[g+1] = carry[g] & atTop;
    end

    assign part[g] = CNT_W'(stVal * STAGE_WGT[g]);
  end

  always_comb begin
    lineCount = '0;
    for (int i = 0; i < NSTAGE; i++)
      lineCount = lineCount + part[i];
  end

  logic [HW_W-1:0] hLeft;
  logic            bkQ;
  logic            hbQ;
  logic            vbQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineStrobe <= 1'b0;
      hPulse     <= 1'b0;
      hLeft      <= '0;
      bkQ        <= 1'b0;
      hbQ        <= 1'b0;
      vbQ        <= 1'b0;
    end else begin
      lineStrobe <= strb.lineTick;
      vbQ        <= vBlank;

      // Width counter keeps a wrapped pulse intact across a select change.
      if (strb.hStart) begin
        hPulse <= 1'b1;
        hLeft  <= HW_W'(H_WIDTH - 1);
      end else if (hLeft != '0) begin
        hLeft <= hLeft - 1'b1;
      end else begin
        hPulse <= 1'b0;
      end

      if (strb.bkOn)
        bkQ <= 1'b1;
      else if (strb.bkOff)
        bkQ <= 1'b0;

      if (strb.hbOn)
        hbQ <= 1'b1;
      else if (strb.hbOff)
        hbQ <= 1'b0;
    end
  end

  // Priority merge: burst key over horizontal blank over vertical blank.
  always_comb begin
    if (bkQ)
      sandcastle = 2'd3;
    else if (hbQ)
      sandcastle = 2'd2;
    else if (vbQ)
      sandcastle = 2'd1;
    else
      sandcastle = 2'd0;
  end

endmodule

// File: rtl/line_sandcastle.sv
module line_sandcastle
  import lsc_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 16,
  parameter int unsigned MID_DIV  = 2,
  parameter int unsigned LINE_DIV = 27,
  parameter int unsigned H_WIDTH  = 49,
  parameter int unsigned H_START0 = 846,
  parameter int unsigned H_START1 = 853,
  parameter int unsigned H_START2 = 54,
  parameter int unsigned H_START3 = 70,
  parameter int unsigned BK_START = 34,
  parameter int unsigned BK_W50   = 58,
  parameter int unsigned BK_W60   = 51,
  parameter int unsigned HB_START = 54,
  parameter int unsigned HB_W     = 159
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] hOffSel,
  input  logic       sel60,
  input  logic       vBlank,
  output logic       lineStrobe,
  output logic       hPulse,
  output logic [1:0] sandcastle
);

  localparam int unsigned LINE_CLKS = PRE_DIV * MID_DIV * LINE_DIV;
  localparam int unsigned CNT_W     = $clog2(LINE_CLKS);

  logic [CNT_W-1:0] lineCount;
  lscStrobe_t       strb;

  lsc_control #(
    .LINE_CLKS(LINE_CLKS), .CNT_W(CNT_W),
    .H_START0(H_START0), .H_START1(H_START1),
    .H_START2(H_START2), .H_START3(H_START3),
    .BK_START(BK_START), .BK_W50(BK_W50), .BK_W60(BK_W60),
    .HB_START(HB_START), .HB_W(HB_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .lineCount(lineCount),
    .hOffSel(hOffSel), .sel60(sel60), .strb(strb)
  );

  lsc_datapath #(
    .PRE_DIV(PRE_DIV), .MID_DIV(MID_DIV), .LINE_DIV(LINE_DIV),
    .H_WIDTH(H_WIDTH), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .vBlank(vBlank),
    .lineCount(lineCount), .lineStrobe(lineStrobe),
    .hPulse(hPulse), .sandcastle(sandcastle)
  );

endmodule

// File: rtl/line_sandcastle_chk.sv
module line_sandcastle_chk #(
  parameter int unsigned LINE_CLKS = 864,
  parameter int unsigned H_WIDTH   = 49,
  parameter int unsigned BK_W50    = 58,
  parameter int unsigned BK_W60    = 51
) (
  input logic       clk,
  input logic       rst,
  input logic       vBlank,
  input logic       lineStrobe,
  input logic       hPulse,
  input logic [1:0] sandcastle
);

  int unsigned gap;
  int unsigned hRun;
  int unsigned bkRun;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= 0;
      hRun  <= 0;
      bkRun <= 0;
      seen  <= 1'b0;
    end else begin
      gap   <= lineStrobe ? 0 : gap + 1;
      hRun  <= hPulse ? hRun + 1 : 0;
      bkRun <= (sandcastle == 2'd3) ? bkRun + 1 : 0;
      if (lineStrobe)
        seen <= 1'b1;
    end
  end

  a_r1_line_period: assert property (@(posedge clk) disable iff (rst)
    (lineStrobe && seen) |-> (gap == LINE_CLKS - 1));

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    lineStrobe |=> !lineStrobe);

  a_r5_hpulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(hPulse) |-> (hRun == H_WIDTH));

  a_r7_burst_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sandcastle == 2'd3) |-> (bkRun == BK_W50 || bkRun == BK_W60));

  a_r9_vblank_level: assert property (@(posedge clk) disable iff (rst)
    vBlank |=> (sandcastle != 2'd0));

endmodule

bind line_sandcastle line_sandcastle_chk #(
  .LINE_CLKS(LINE_CLKS), .H_WIDTH(H_WIDTH), .BK_W50(BK_W50), .BK_W60(BK_W60)
) chk_i (
  .clk(clk), .rst(rst), .vBlank(vBlank), .lineStrobe(lineStrobe),
  .hPulse(hPulse), .sandcastle(sandcastle)
);

// File: tb/line_sandcastle_tb_top.sv
`timescale 1ns/1ps
module line_sandcastle_tb_top;

  localparam int LINE     = 864;
  localparam int H_W      = 49;
  localparam int BK_START = 34;
  localparam int HB_START = 54;
  localparam int HB_END   = 213;
  localparam int WIN      = LINE + 60;
  localparam int NVEC     = 6;
  // Columns: hOffSel, sel60, vBlank, expected pulse start, expected burst width
  localparam int VEC[NVEC][5] = '{
    '{0, 0, 0, 846, 58},
    '{1, 1, 0, 853, 51},
    '{2, 0, 1,  54, 58},
    '{3, 1, 1,  70, 51},
    '{2, 1, 0,  54, 51},
    '{0, 0, 1, 846, 58}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] hOffSel = 2'd0;
  logic       sel60 = 1'b0;
  logic       vBlank = 1'b0;
  logic       lineStrobe;
  logic       hPulse;
  logic [1:0] sandcastle;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic       capH [WIN];
  logic [1:0] capS [WIN];

  always #2 clk = ~clk;

  line_sandcastle dut_i (
    .clk(clk), .rst(rst), .hOffSel(hOffSel), .sel60(sel60), .vBlank(vBlank),
    .lineStrobe(lineStrobe), .hPulse(hPulse), .sandcastle(sandcastle)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!lineStrobe);
  endtask

  // Sample one line plus 60 clocks, optionally changing selects at clock chgAt.
  task automatic capture(input int chgAt, input logic [1:0] newOff, input logic new60);
    waitStrobe();
    capH[0] = hPulse;
    capS[0] = sandcastle;
    for (int c = 1; c < WIN; c++) begin
      if (c == chgAt) begin
        hOffSel = newOff;
        sel60   = new60;
      end
      @(negedge clk);
      capH[c] = hPulse;
      capS[c] = sandcastle;
    end
  endtask

  function automatic int risingEdge();
    for (int c = 1; c < LINE; c++)
      if (capH[c] && !capH[c-1]) return c;
    return -1;
  endfunction

  function automatic int widthFrom(input int s);
    int n = 0;
    if (s < 0) return 0;
    for (int c = s; c < WIN; c++) begin
      if (!capH[c]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int expLevel(input int c, input int bkW, input bit vb);
    if (c >= BK_START && c < BK_START + bkW) return 3;
    if (c >= HB_START && c < HB_END) return 2;
    return vb ? 1 : 0;
  endfunction

  task automatic checkLevels(input string req, input int bkW, input bit vb);
    int bad = -1;
    for (int c = 0; c < LINE; c++)
      if (bad < 0 && int'(capS[c]) != expLevel(c, bkW, vb)) bad = c;
    if (bad < 0) check(req, 0, 0);
    else begin
      $display("  first level mismatch at clock %0d", bad);
      check(req, int'(capS[bad]), expLevel(bad, bkW, vb));
    end
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish();
    end
  end

  initial begin
    int n;
    // R3: reset state, vBlank high must not reach the output
    vBlank = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 lineStrobe in reset", lineStrobe, 0);
    check("R3 hPulse in reset", hPulse, 0);
    check("R3 sandcastle in reset", sandcastle, 0);
    vBlank = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R2 strobe after release", lineStrobe, 1);
    @(negedge clk);
    check("R1 strobe one clock wide", lineStrobe, 0);
    n = 1;
    while (!lineStrobe) begin
      @(negedge clk);
      n++;
    end
    check("R1 line period", n, LINE);

    // Vector table: each row is applied one line ahead of its measured line.
    for (int v = 0; v < NVEC; v++) begin
      hOffSel = 2'(VEC[v][0]);
      sel60   = VEC[v][1][0];
      vBlank  = VEC[v][2][0];
      capture(-1, 2'd0, 1'b0);
      check($sformatf("R4 vec%0d pulse start", v), risingEdge(), VEC[v][3]);
      check($sformatf("R5 vec%0d pulse width", v), widthFrom(risingEdge()), H_W);
      checkLevels($sformatf("R7 R8 R9 vec%0d levels", v), VEC[v][4], VEC[v][2][0]);
    end

    // R6: mid-line change is held off until the next line
    hOffSel = 2'd2;
    sel60   = 1'b0;
    vBlank  = 1'b0;
    capture(-1, 2'd0, 1'b0);
    capture(10, 2'd3, 1'b1);
    check("R6 start unchanged in current line", risingEdge(), 54);
    check("R6 width unchanged in current line", widthFrom(risingEdge()), H_W);
    checkLevels("R6 burst width unchanged in current line", 58, 1'b0);
    capture(-1, 2'd0, 1'b0);
    check("R6 start after boundary", risingEdge(), 70);
    checkLevels("R6 burst width after boundary", 51, 1'b0);

    // R3/R2: reset in the middle of active pulses
    repeat (40) @(negedge clk);
    check("R8 blank level before mid-run reset", sandcastle, 2);
    check("R4 pulse active before mid-run reset", hPulse, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R3 hPulse cleared by reset", hPulse, 0);
    check("R3 sandcastle cleared by reset", sandcastle, 0);
    check("R3 lineStrobe cleared by reset", lineStrobe, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 strobe after second release", lineStrobe, 1);
    finish();
  end

endmodule